// File: doc/BRIEF.md
# Frame-Synced Serial Deviation Word Receiver

This block takes frequency deviation words for a frequency-shift-keyed synthesizer from a three-wire serial link: a bit clock, a frame sync and a data line. These three lines are the same pins that carry symbols when symbol selection comes from pins. The receiver only listens when the serial deviation mode is enabled. Each frame holds one 16-bit word. Bits are shifted in while the frame sync is at its active level, and a control bit picks whether that level is high or low. The opposite level separates frames and lasts at least one bit clock, so a frame is never shorter than 17 bit clocks.

The serial side runs on the bit clock, which may reach 100 MHz. When the frame sync returns to its inactive level, the shifter closes the frame and flips a toggle. A synchronizer in the system clock domain turns that toggle into a one-cycle pulse. A frame with all 16 bits produces a new output word and a valid pulse. A frame with fewer bits produces a short-frame pulse and leaves the output word unchanged.

Top module: `fsk_serial_word_rx`

## Requirements
- R1: While rst_n is low, word_valid and short_frame are 0 and word_out is 0.
- R2: Data bits are sampled on the rising edge of ser_clk while ser_fs equals fs_pol (fs_pol=1 means high is active, fs_pol=0 means low is active). The first bit sampled becomes word_out[15] (MSB first).
- R3: The frame is closed by the first rising ser_clk edge that samples ser_fs at its inactive level after an active phase. If that phase held at least 16 bits, word_out takes the new word and word_valid is high for exactly one sys_clk cycle. word_out changes at no other time.
- R4: An active phase with 1 to 15 bits raises short_frame for one sys_clk cycle, gives no word_valid, and leaves word_out unchanged.
- R5: Bits beyond the 16th in one active phase are ignored, so word_out holds the first 16 bits of that phase.
- R6: While mode_en is 0, activity on ser_fs and ser_data produces no pulse and does not change word_out.
- R7: Frames of the minimum length (16 active bit clocks followed by one inactive bit clock) sent back to back are each delivered, in order.
- R8: With the default two synchronizer stages, the pulse for a frame appears on the third or fourth rising sys_clk edge after the ser_clk edge that closes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, the domain where results are delivered |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode_en | input | 1 | Serial deviation mode enable; changed only while the link is idle |
| fs_pol | input | 1 | Active frame sync level: 1 means high, 0 means low |
| ser_clk | input | 1 | Serial bit clock |
| ser_fs | input | 1 | Frame sync |
| ser_data | input | 1 | Serial data, MSB first |
| word_out | output | 16 | Last complete deviation word |
| word_valid | output | 1 | One-cycle pulse: word_out has been updated |
| short_frame | output | 1 | One-cycle pulse: the last frame had fewer than 16 bits |

## Verification
Each frame's result depends on the alignment of two unrelated clocks, so it has no single fixed due cycle. Its due time lies in a window that starts at the ser_clk edge that samples the inactive frame sync. It ends two to four sys_clk periods later, plus the half period it takes to sample at the falling edge. The driver records the time of that closing edge with each expected item. When a pulse is popped, the monitor checks that the elapsed time falls inside the window and that pulses arrive in send order. Frames sent with the mode disabled push no item, so any pulse that shows up for them is reported as unexpected.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;

   // Kind of event closed by the serial side
   typedef enum logic {
      EV_WORD  = 1'b0,
      EV_SHORT = 1'b1
   } ev_kind_e;

   localparam int unsigned DEF_WORD_W      = 16;
   localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/fsk_rx_shifter.sv
// Serial-clock-domain capture: shifts bits during the active frame sync phase,
// closes the frame on return to the inactive level and flips an event toggle.
module fsk_rx_shifter
   import fsk_rx_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic              ser_clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic              fs_pol,
   input  logic              ser_fs,
   input  logic              ser_data,
   output logic              evt_tgl,
   output logic [WORD_W-1:0] hold_word,
   output ev_kind_e          hold_kind
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

   logic              in_active;
   logic              was_active;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] shreg;
   logic              full;

   assign in_active = mode_en && (ser_fs == fs_pol);
   assign full      = (bit_cnt == FULL_CNT);

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         was_active <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
         evt_tgl    <= 1'b0;
         hold_word  <= '0;
         hold_kind  <= EV_WORD;
      end else if (!mode_en) begin
         was_active <= 1'b0;
         bit_cnt    <= '0;
      end else begin
         was_active <= in_active;
         if (in_active) begin
            if (!full) begin
               shreg   <= {shreg[WORD_W-2:0], ser_data};
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else if (was_active) begin
            bit_cnt <= '0;
            evt_tgl <= ~evt_tgl;
            if (full) begin
               hold_word <= shreg;
               hold_kind <= EV_WORD;
            end else begin
               hold_kind <= EV_SHORT;
            end
         end
      end
   end

endmodule

// File: rtl/fsk_rx_cdc.sv
// System-clock-domain side: toggle synchronizer, edge detect, output registers.
module fsk_rx_cdc
   import fsk_rx_pkg::*;
#(
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              evt_tgl,
   input  logic [WORD_W-1:0] hold_word,
   input  ev_kind_e          hold_kind,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid,
   output logic              short_frame
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen_q;
   logic                   evt_edge;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= evt_tgl;
         end
      end else begin : g_next
         always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign evt_edge = sync_q[SYNC_STAGES-1] ^ seen_q;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q      <= 1'b0;
         word_out    <= '0;
         word_valid  <= 1'b0;
         short_frame <= 1'b0;
      end else begin
         seen_q      <= sync_q[SYNC_STAGES-1];
         word_valid  <= evt_edge && (hold_kind == EV_WORD);
         short_frame <= evt_edge && (hold_kind == EV_SHORT);
         if (evt_edge && (hold_kind == EV_WORD)) word_out <= hold_word;
      end
   end

endmodule

// File: rtl/fsk_serial_word_rx.sv
module fsk_serial_word_rx
   import fsk_rx_pkg::*;
#(
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic              fs_pol,
   input  logic              ser_clk,
   input  logic              ser_fs,
   input  logic              ser_data,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid,
   output logic              short_frame
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);

   if (WORD_W < 2) begin : g_bad_width
      $error("fsk_serial_word_rx: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fsk_serial_word_rx: SYNC_STAGES must be at least 2");
   end

   logic              evt_tgl;
   logic [WORD_W-1:0] hold_word;
   ev_kind_e          hold_kind;

   fsk_rx_shifter #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) u_shift (
      .ser_clk   (ser_clk),
      .rst_n     (rst_n),
      .mode_en   (mode_en),
      .fs_pol    (fs_pol),
      .ser_fs    (ser_fs),
      .ser_data  (ser_data),
      .evt_tgl   (evt_tgl),
      .hold_word (hold_word),
      .hold_kind (hold_kind)
   );

   fsk_rx_cdc #(
      .WORD_W      (WORD_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cdc (
      .sys_clk     (sys_clk),
      .rst_n       (rst_n),
      .evt_tgl     (evt_tgl),
      .hold_word   (hold_word),
      .hold_kind   (hold_kind),
      .word_out    (word_out),
      .word_valid  (word_valid),
      .short_frame (short_frame)
   );

endmodule

// File: rtl/fsk_serial_word_rx_chk.sv
module fsk_serial_word_rx_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              sys_clk,
   input logic              ser_clk,
   input logic              rst_n,
   input logic              mode_en,
   input logic              fs_pol,
   input logic              ser_fs,
   input logic              evt_tgl,
   input logic [WORD_W-1:0] word_out,
   input logic              word_valid,
   input logic              short_frame
);

   // R3
   valid_one_cycle_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R3
   word_only_on_valid_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (word_out != $past(word_out)) |-> word_valid);

   // R4
   short_keeps_word_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      short_frame |-> $stable(word_out));

   // R6
   disabled_no_event_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      !mode_en |=> $stable(evt_tgl));

   // R3
   close_on_inactive_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (evt_tgl != $past(evt_tgl)) |-> ($past(ser_fs) != fs_pol));

endmodule

bind fsk_serial_word_rx fsk_serial_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
   .sys_clk     (sys_clk),
   .ser_clk     (ser_clk),
   .rst_n       (rst_n),
   .mode_en     (mode_en),
   .fs_pol      (fs_pol),
   .ser_fs      (ser_fs),
   .evt_tgl     (evt_tgl),
   .word_out    (word_out),
   .word_valid  (word_valid),
   .short_frame (short_frame)
);

// File: tb/test_fsk_serial_word_rx.sv
module test_fsk_serial_word_rx;

   logic        sys_clk = 1'b0;
   logic        ser_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic        mode_en = 1'b1;
   logic        fs_pol  = 1'b1;
   logic        ser_fs  = 1'b0;
   logic        ser_data = 1'b0;
   logic [15:0] word_out;
   logic        word_valid;
   logic        short_frame;

   int tests = 0;
   int fails = 0;
   int pulses = 0;
   bit done = 1'b0;

   typedef struct {
      logic        err;
      logic [15:0] word;
      time         stamp;
      string       tag;
   } exp_t;

   exp_t        q[$];
   exp_t        cur;
   logic [15:0] exp_last = 16'h0000;

   fsk_serial_word_rx i_fsk_serial_word_rx (
      .sys_clk     (sys_clk),
      .rst_n       (rst_n),
      .mode_en     (mode_en),
      .fs_pol      (fs_pol),
      .ser_clk     (ser_clk),
      .ser_fs      (ser_fs),
      .ser_data    (ser_data),
      .word_out    (word_out),
      .word_valid  (word_valid),
      .short_frame (short_frame)
   );

   // 250 MHz system clock, offset so its edges never meet the serial edges
   initial begin
      #1;
      forever #2 sys_clk = ~sys_clk;
   end

   always #10 ser_clk = ~ser_clk;

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Driver: one frame, nbits active clocks then gap inactive clocks
   task automatic send_frame(input logic [15:0] w, input int nbits, input int gap,
                             input bit expect_out, input string tag);
      exp_t e;
      for (int i = 0; i < nbits; i++) begin
         @(negedge ser_clk);
         ser_fs   = fs_pol;
         ser_data = (i < 16) ? w[15-i] : ~i[0];
      end
      @(negedge ser_clk);
      ser_fs   = ~fs_pol;
      ser_data = 1'b0;
      @(posedge ser_clk);
      if (expect_out) begin
         e.err   = (nbits < 16);
         if (nbits >= 16) exp_last = w;
         e.word  = exp_last;
         e.stamp = $time;
         e.tag   = tag;
         q.push_back(e);
      end
      for (int g = 1; g < gap; g++) @(negedge ser_clk);
   endtask

   task automatic set_pol(input logic p);
      @(negedge ser_clk);
      mode_en = 1'b0;
      repeat (2) @(negedge ser_clk);
      fs_pol = p;
      ser_fs = ~p;
      repeat (2) @(negedge ser_clk);
      mode_en = 1'b1;
      @(negedge ser_clk);
   endtask

   task automatic drain();
      repeat (12) @(negedge sys_clk);
      check(q.size() == 0, "R8", "items still pending", q.size(), 0);
   endtask

   // Monitor: pops expected items as pulses appear
   always @(negedge sys_clk) begin
      if (rst_n && !done && (word_valid || short_frame)) begin
         pulses++;
         if (q.size() == 0) begin
            check(1'b0, "R6", "unexpected pulse", {word_valid, short_frame}, 0);
         end else begin
            cur = q.pop_front();
            check(word_valid == !cur.err, cur.err ? "R4" : "R3", "word_valid",
                  word_valid, !cur.err);
            check(short_frame == cur.err, cur.err ? "R4" : "R3", "short_frame",
                  short_frame, cur.err);
            check(word_out == cur.word, cur.tag, "word_out", word_out, cur.word);
            check(($time - cur.stamp) >= 8 && ($time - cur.stamp) <= 18, "R8",
                  "latency ns", 32'($time - cur.stamp), 18);
         end
      end
   end

   initial begin
      #(200000 * 4);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int p0;
      logic [15:0] w0;
      // R1: reset state
      repeat (5) @(negedge sys_clk);
      check(word_valid == 1'b0, "R1", "word_valid in reset", word_valid, 0);
      check(short_frame == 1'b0, "R1", "short_frame in reset", short_frame, 0);
      check(word_out == 16'h0, "R1", "word_out in reset", word_out, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge ser_clk);

      // R2: active-high polarity, several patterns
      send_frame(16'hA5C3, 16, 3, 1'b1, "R2");
      send_frame(16'h8000, 16, 3, 1'b1, "R2");
      send_frame(16'h0001, 16, 3, 1'b1, "R2");
      send_frame(16'hFFFF, 16, 3, 1'b1, "R2");
      send_frame(16'h0000, 16, 3, 1'b1, "R2");
      drain();

      // R7: back-to-back minimum frames
      send_frame(16'h1234, 16, 1, 1'b1, "R7");
      send_frame(16'hFEDC, 16, 1, 1'b1, "R7");
      send_frame(16'h5A5A, 16, 1, 1'b1, "R7");
      send_frame(16'h0F0F, 16, 3, 1'b1, "R7");
      drain();

      // R4: short frames keep the word
      send_frame(16'hBEEF, 15, 3, 1'b1, "R4");
      send_frame(16'hCAFE, 1, 3, 1'b1, "R4");
      drain();
      check(word_out == 16'h0F0F, "R4", "word_out after short", word_out, 16'h0F0F);

      // R5: extra bits ignored
      send_frame(16'h3C96, 21, 3, 1'b1, "R5");
      drain();

      // R2: active-low polarity
      set_pol(1'b0);
      send_frame(16'h6E21, 16, 3, 1'b1, "R2");
      send_frame(16'h9001, 16, 1, 1'b1, "R2");
      send_frame(16'hABCD, 10, 3, 1'b1, "R4");
      drain();

      // R6: disabled mode ignores the pins
      @(negedge ser_clk);
      mode_en = 1'b0;
      p0 = pulses;
      w0 = word_out;
      send_frame(16'h7777, 16, 3, 1'b0, "R6");
      send_frame(16'h1111, 20, 3, 1'b0, "R6");
      repeat (12) @(negedge sys_clk);
      check(pulses == p0, "R6", "pulses while disabled", pulses, p0);
      check(word_out == w0, "R6", "word_out while disabled", word_out, w0);
      @(negedge ser_clk);
      mode_en = 1'b1;
      repeat (2) @(negedge ser_clk);
      send_frame(16'h2468, 16, 3, 1'b1, "R3");
      drain();

      finish_run();
   end

endmodule